// File: doc/BRIEF.md
# Inverter Operating Mode Sequencer

This block is the supervisory state machine of a grid-tied inverter controller. It steps the converter through five operating modes: power-on, standby, soft start, normal output and fault. It decides from those modes whether the PWM stage and the output relay are allowed on. Its inputs are the controller's initialisation-done flag, start and shutdown commands, a soft-start success indication, an error indication such as bus overvoltage, and a fault-clear request from a button or a host. It does not run the control loops or generate PWM. It only gates the enables that those parts obey.

The error input has priority over every other input and latches the machine in the fault mode. Only an explicit clear, given while the error has gone away, leaves that mode, and the machine then always returns to standby. The PWM enable and relay outputs are also gated combinationally by the error input, so they drop in the same cycle the error shows up and do not wait one clock for the state register. A soft start that is not confirmed within a parameterised number of cycles is treated as a fault.

Top module: `inverter_mode_seq`

## Requirements
- R1: While reset is low and after it is released, the mode is power-on, with pwmEn and relayClose low. The mode code is 0 = power-on, 1 = standby, 2 = soft start, 3 = normal, 4 = fault. Power-on is held while initDone is low.
- R2: In power-on, initDone high with no error moves the mode to standby at the next clock edge.
- R3: In standby, pwmEn and relayClose are low. startCmd with no error moves the mode to soft start at the next edge.
- R4: In soft start and normal, with errIn low, pwmEn and relayClose are both high.
- R5: In soft start, rampOk high moves the mode to normal at the next edge, even in the last cycle of the soft-start window.
- R6: stopCmd in soft start or normal, with no error, moves the mode to standby at the next edge. In soft start, stopCmd wins over rampOk.
- R7: errIn high in any mode moves the mode to fault at the next edge, over every other input.
- R8: pwmEn and relayClose are low in every cycle in which errIn is high, including the cycle before the mode register changes.
- R9: In fault mode, pwmEn and relayClose are low, and the mode stays fault until a valid clear, even after errIn drops.
- R10: clearReq in fault mode is ignored while errIn is high. clearReq with errIn low moves the mode to standby at the next edge.
- R11: If soft start lasts RAMP_CYCLES cycles without rampOk, the mode becomes fault at the edge that ends the RAMP_CYCLES-th cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initDone | input | 1 | Controller initialisation complete |
| startCmd | input | 1 | Start command |
| stopCmd | input | 1 | Shutdown command |
| rampOk | input | 1 | Soft start reported successful |
| errIn | input | 1 | Error present (e.g. bus overvoltage) |
| clearReq | input | 1 | Fault clear request |
| pwmEn | output | 1 | PWM stage enable |
| relayClose | output | 1 | Output relay close command |
| modeCode | output | 3 | Current operating mode code |

## Verification
The assertions check the rules that hold on every cycle. The outputs are low whenever errIn is high or the mode is standby or fault. The next mode after an error, after a valid or an ignored clear, and after a shutdown is as the requirements state. Only the bench's scenarios can show the soft-start timeout landing on exactly the RAMP_CYCLES-th cycle. The same goes for rampOk winning in the final window cycle, stopCmd winning over rampOk, and the complete start-up path from power-on through normal output.

// File: rtl/invseq_pkg.sv
package invseq_pkg;
  typedef enum logic [2:0] {
    MODE_PWRON = 3'd0,
    MODE_IDLE  = 3'd1,
    MODE_RAMP  = 3'd2,
    MODE_RUN   = 3'd3,
    MODE_TRIP  = 3'd4
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rampClr;
    logic rampRun;
    logic outReq;
  } seqStrobe_t;
endpackage

// File: rtl/invseq_ctrl.sv
module invseq_ctrl
  import invseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       initDone,
  input  logic       startCmd,
  input  logic       stopCmd,
  input  logic       rampOk,
  input  logic       errIn,
  input  logic       clearReq,
  input  logic       rampExpired,
  output mode_e      mode,
  output seqStrobe_t strb
);
  mode_e modeNext;

  always_comb begin
    modeNext = mode;
    if (errIn) begin
      modeNext = MODE_TRIP;
    end else begin
      unique case (mode)
        MODE_PWRON: if (initDone) modeNext = MODE_IDLE;
        MODE_IDLE:  if (startCmd) modeNext = MODE_RAMP;
        MODE_RAMP: begin
          if (stopCmd)          modeNext = MODE_IDLE;
          else if (rampOk)      modeNext = MODE_RUN;
          else if (rampExpired) modeNext = MODE_TRIP;
        end
        MODE_RUN:   if (stopCmd)  modeNext = MODE_IDLE;
        MODE_TRIP:  if (clearReq) modeNext = MODE_IDLE;
        default:    modeNext = MODE_TRIP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) mode <= MODE_PWRON;
    else       mode <= modeNext;
  end

  always_comb begin
    strb.rampRun = (mode == MODE_RAMP);
    strb.rampClr = (mode != MODE_RAMP);
    strb.outReq  = (mode == MODE_RAMP) || (mode == MODE_RUN);
  end
endmodule

// File: rtl/invseq_dp.sv
module invseq_dp
  import invseq_pkg::*;
#(
  parameter int RAMP_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic       errIn,
  output logic       rampExpired,
  output logic       pwmEn,
  output logic       relayClose
);
  localparam int CNT_W = $clog2(RAMP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RAMP_CYCLES - 1);

  logic [CNT_W-1:0] rampCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strb.rampClr) rampCnt <= '0;
    else if (strb.rampRun && rampCnt != LAST) rampCnt <= rampCnt + 1'b1;
  end

  assign rampExpired = strb.rampRun && (rampCnt == LAST);

  // error gates the power stage without waiting for the state register
  logic gateOn;
  assign gateOn     = strb.outReq && !errIn;
  assign pwmEn      = gateOn;
  assign relayClose = gateOn;
endmodule

// File: rtl/inverter_mode_seq.sv
module inverter_mode_seq
  import invseq_pkg::*;
#(
  parameter int RAMP_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       initDone,
  input  logic       startCmd,
  input  logic       stopCmd,
  input  logic       rampOk,
  input  logic       errIn,
  input  logic       clearReq,
  output logic       pwmEn,
  output logic       relayClose,
  output logic [2:0] modeCode
);
  mode_e      mode;
  seqStrobe_t strb;
  logic       rampExpired;

  invseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .initDone(initDone), .startCmd(startCmd),
    .stopCmd(stopCmd), .rampOk(rampOk), .errIn(errIn), .clearReq(clearReq),
    .rampExpired(rampExpired), .mode(mode), .strb(strb)
  );

  invseq_dp #(.RAMP_CYCLES(RAMP_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .errIn(errIn),
    .rampExpired(rampExpired), .pwmEn(pwmEn), .relayClose(relayClose)
  );

  assign modeCode = mode;
endmodule

// File: rtl/inverter_mode_seq_chk.sv
module inverter_mode_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startCmd,
  input logic       stopCmd,
  input logic       errIn,
  input logic       clearReq,
  input logic       pwmEn,
  input logic       relayClose,
  input logic [2:0] modeCode
);
  // R8
  err_gates_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    errIn |-> (!pwmEn && !relayClose));
  // R3
  idle_out_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd1) |-> (!pwmEn && !relayClose));
  // R9
  trip_out_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd4) |-> (!pwmEn && !relayClose));
  // R7
  err_to_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    errIn |=> (modeCode == 3'd4));
  // R10
  clear_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd4 && clearReq && errIn) |=> (modeCode == 3'd4));
  // R10
  clear_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd4 && clearReq && !errIn) |=> (modeCode == 3'd1));
  // R9
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd4 && !clearReq) |=> (modeCode == 3'd4));
  // R6
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((modeCode == 3'd2 || modeCode == 3'd3) && stopCmd && !errIn) |=> (modeCode == 3'd1));
  // R4
  run_out_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((modeCode == 3'd2 || modeCode == 3'd3) && !errIn) |-> (pwmEn && relayClose));
  // R3
  start_to_ramp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd1 && startCmd && !errIn) |=> (modeCode == 3'd2));
endmodule

bind inverter_mode_seq inverter_mode_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .startCmd(startCmd), .stopCmd(stopCmd),
  .errIn(errIn), .clearReq(clearReq), .pwmEn(pwmEn),
  .relayClose(relayClose), .modeCode(modeCode)
);

// File: tb/inverter_mode_seq_tb.sv
module inverter_mode_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RAMP = 8;

  logic clk = 1'b0;
  logic rstN, initDone, startCmd, stopCmd, rampOk, errIn, clearReq;
  logic pwmEn, relayClose;
  logic [2:0] modeCode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inverter_mode_seq #(.RAMP_CYCLES(RAMP)) u_dut (
    .clk(clk), .rstN(rstN), .initDone(initDone), .startCmd(startCmd),
    .stopCmd(stopCmd), .rampOk(rampOk), .errIn(errIn), .clearReq(clearReq),
    .pwmEn(pwmEn), .relayClose(relayClose), .modeCode(modeCode)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chkOut(input string req, input int m, input int on);
    chk(req, modeCode, m);
    chk(req, pwmEn, on);
    chk(req, relayClose, on);
  endtask

  // advance one clock, sample 1 time unit after the edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idleIn();
    initDone = 0; startCmd = 0; stopCmd = 0; rampOk = 0; errIn = 0; clearReq = 0;
  endtask

  task automatic doReset();
    idleIn();
    rstN = 0;
    tick(); tick();
    chkOut("R1 reset", 0, 0);
    rstN = 1;
    tick(); tick();
    chkOut("R1 hold power-on", 0, 0);
  endtask

  task automatic toIdle();
    initDone = 1; tick(); initDone = 0;
    chkOut("R2 boot to standby", 1, 0);
  endtask

  task automatic toRamp();
    startCmd = 1; tick(); startCmd = 0;
    chkOut("R4 soft start outputs", 2, 1);
  endtask

  task automatic testBoot();
    doReset();
    toIdle();
    tick();
    chkOut("R3 standby holds off", 1, 0);
    toRamp();
    rampOk = 1; tick(); rampOk = 0;
    chkOut("R5 normal outputs", 3, 1);
    tick(); tick();
    chkOut("R4 normal held", 3, 1);
  endtask

  task automatic testStop();
    stopCmd = 1; tick(); stopCmd = 0;
    chkOut("R6 stop from normal", 1, 0);
    toRamp();
    stopCmd = 1; rampOk = 1; tick(); stopCmd = 0; rampOk = 0;
    chkOut("R6 stop beats rampOk", 1, 0);
  endtask

  task automatic testFault();
    toRamp();
    rampOk = 1; tick(); rampOk = 0;
    errIn = 1; #1;
    chkOut("R8 same-cycle gating", 3, 0);
    tick();
    chkOut("R7 error to fault", 4, 0);
    clearReq = 1; tick(); clearReq = 0;
    chkOut("R10 clear ignored with error", 4, 0);
    errIn = 0; tick(); tick();
    chkOut("R9 fault latched", 4, 0);
    clearReq = 1; tick(); clearReq = 0;
    chkOut("R10 clear to standby", 1, 0);
    startCmd = 1; errIn = 1; tick(); startCmd = 0; errIn = 0;
    chkOut("R7 error beats start", 4, 0);
    clearReq = 1; tick(); clearReq = 0;
    chkOut("R10 clear again", 1, 0);
  endtask

  task automatic testTimeout();
    toRamp();
    for (int i = 0; i < RAMP - 1; i++) tick();
    chkOut("R11 last window cycle", 2, 1);
    tick();
    chkOut("R11 timeout fault", 4, 0);
    clearReq = 1; tick(); clearReq = 0;
    toRamp();
    for (int i = 0; i < RAMP - 1; i++) tick();
    rampOk = 1; tick(); rampOk = 0;
    chkOut("R5 rampOk in last cycle", 3, 1);
  endtask

  task automatic testPowerOnErr();
    doReset();
    errIn = 1; initDone = 1; tick(); errIn = 0; initDone = 0;
    chkOut("R7 error in power-on", 4, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rstN = 0;
    idleIn();
    testBoot();
    testStop();
    testFault();
    testTimeout();
    testPowerOnErr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule